// File: doc/BRIEF.md
# Pulse-Width Bus Frame Master

This block is the protocol engine on the master side of a two-wire pulse-width sensor bus. A command word is handed over with a one-cycle start strobe when the engine is ready. The engine then pulls an active-low frame line and waits one bit time. After that it sends the data bits, most significant first, followed by an automatically generated CRC. Each bit is sent on an active-low data line, and the width of the low pulse carries the value. While each bit goes out, the engine also reads the reply on a return line and shifts it into a receive register. At the end it reports the reply together with a CRC-mismatch flag.

All bus timing comes from an external strobe, `bit_third`, that fires once per third of a bit time. One bit therefore spans three strobes: the data line is low for one strobe to send a 1 and for two strobes to send a 0. The data length, the CRC length and the minimum idle gap before the next frame are sampled when a command is accepted. Lengths outside the supported range are clamped.

Top module: `pwb_frame_engine`

## Requirements
- R1: After reset, `frame_n` and `data_n` are 1, `ready` is 1 and `rx_valid` is 0.
- R2: An accepted `start` (with `ready` high) lowers `frame_n` on the next `bit_third` strobe. `data_n` stays high for the following three strobes, and the first data bit falls on the third strobe after the frame fell.
- R3: Every bit slot lasts three strobes and begins with `data_n` falling. `data_n` is low for exactly one strobe for a 1 and for two strobes for a 0, and high for the rest of the slot.
- R4: Bits are sent as `tx_data[L-1]` down to `tx_data[0]` (L being the effective data length), followed by the CRC bits, most significant first.
- R5: The CRC has the effective CRC length C and the polynomial x^C + x + 1 (tap mask 0x03 reduced to C bits). It starts from zero and is fed one data bit at a time, most significant first. A CRC length of 0 sends no CRC bits.
- R6: `frame_n` rises on the strobe that ends the last bit, so that it has been low for 3*(1+L+C) strobes.
- R7: `ret_in` is sampled on the strobe that ends each bit. The data part is returned right-aligned in `rx_data` with the upper bits zero. `rx_valid` is a single-cycle pulse in the cycle in which `frame_n` has just risen.
- R8: `rx_crc_err` is 1 exactly when the received CRC bits differ from the CRC computed over the received data bits. It is always 0 when C is 0.
- R9: After `frame_n` rises, `ready` stays low, and `frame_n` does not fall again, for at least 3*G strobes, G being the `gap_len` sampled with the previous command.
- R10: Data lengths below 8 are raised to 8 and those above 16 are lowered to 16. CRC lengths above 8 are lowered to 8.
- R11: `start` is ignored while `ready` is low. Inputs that change after acceptance do not alter the frame, and no frame begins without an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_third | input | 1 | Timing strobe, one pulse per third of a bit time |
| start | input | 1 | Command strobe, accepted when `ready` is high |
| tx_data | input | 16 | Command data, right-aligned |
| data_len | input | 5 | Requested data length in bits |
| crc_len | input | 4 | Requested CRC length in bits |
| gap_len | input | 8 | Minimum idle after this frame, in bit times |
| ret_in | input | 1 | Return line from the bus |
| frame_n | output | 1 | Active-low frame line |
| data_n | output | 1 | Active-low pulse-width data line |
| ready | output | 1 | Engine idle and able to accept a command |
| rx_valid | output | 1 | One-cycle pulse: received result present |
| rx_data | output | 16 | Received data bits, right-aligned |
| rx_crc_err | output | 1 | CRC mismatch on the received frame |

## Verification
A wrong bit counter or wrong length latch shows up as a frame that is too long or too short. This appears at `frame_n` on the very strobe where the frame should close. A wrong phase counter distorts the pulse widths of the next bit slot, so decoding the data line strobe by strobe catches it within one bit time. An error in either CRC accumulator only becomes visible at the end of the frame: as wrong trailing bits on `data_n`, or as a wrong `rx_crc_err`. For that reason both good and corrupted replies are driven, with several CRC lengths.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_LEAD = 3'd2,
        ST_BITS = 3'd3,
        ST_GAP  = 3'd4
    } pwb_state_e;

    localparam int unsigned STROBES_PER_BIT = 3;

endpackage

// File: rtl/pwb_len_clamp.sv
module pwb_len_clamp #(
    parameter int unsigned DATA_MIN = 8,
    parameter int unsigned DATA_MAX = 16,
    parameter int unsigned CRC_MAX  = 8,
    localparam int unsigned DLEN_W  = $clog2(DATA_MAX + 1),
    localparam int unsigned CLEN_W  = $clog2(CRC_MAX + 1)
) (
    input  logic [DLEN_W-1:0] raw_dlen,
    input  logic [CLEN_W-1:0] raw_clen,
    output logic [DLEN_W-1:0] lim_dlen,
    output logic [CLEN_W-1:0] lim_clen
);

    always_comb begin
        if (raw_dlen < DLEN_W'(DATA_MIN)) begin
            lim_dlen = DLEN_W'(DATA_MIN);
        end else if (raw_dlen > DLEN_W'(DATA_MAX)) begin
            lim_dlen = DLEN_W'(DATA_MAX);
        end else begin
            lim_dlen = raw_dlen;
        end

        if (raw_clen > CLEN_W'(CRC_MAX)) begin
            lim_clen = CLEN_W'(CRC_MAX);
        end else begin
            lim_clen = raw_clen;
        end
    end

endmodule

// File: rtl/pwb_crc_acc.sv
module pwb_crc_acc #(
    parameter int unsigned CRC_MAX = 8,
    parameter logic [CRC_MAX-1:0] TAPS = 'h03,
    localparam int unsigned CLEN_W = $clog2(CRC_MAX + 1),
    localparam int unsigned CPOS_W = $clog2(CRC_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               din,
    input  logic [CLEN_W-1:0]  len,
    output logic [CRC_MAX-1:0] crc
);

    logic [CRC_MAX-1:0] crc_d, crc_q;
    logic [CRC_MAX-1:0] len_mask;
    logic [CRC_MAX-1:0] shifted;
    logic               top_bit;
    logic               feedback;

    always_comb begin
        for (int i = 0; i < CRC_MAX; i++) begin
            len_mask[i] = (i < int'(len));
        end
        top_bit  = (len == '0) ? 1'b0 : crc_q[CPOS_W'(len - CLEN_W'(1))];
        feedback = top_bit ^ din;
        shifted  = CRC_MAX'({crc_q, 1'b0});

        crc_d = crc_q;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = (shifted ^ (feedback ? TAPS : '0)) & len_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/pwb_gap_timer.sv
module pwb_gap_timer #(
    parameter int unsigned GAP_W = 8,
    localparam int unsigned REM_W = GAP_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] count,
    input  logic             tick,
    output logic             expired
);

    logic [REM_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load) begin
            rem_d = {2'b00, count} + {1'b0, count, 1'b0};
        end else if (tick && (rem_q != '0)) begin
            rem_d = rem_q - REM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign expired = (rem_q == '0);

endmodule

// File: rtl/pwb_frame_engine.sv
module pwb_frame_engine
    import pwb_pkg::*;
#(
    parameter int unsigned DATA_MIN = 8,
    parameter int unsigned DATA_MAX = 16,
    parameter int unsigned CRC_MAX  = 8,
    parameter logic [CRC_MAX-1:0] CRC_TAPS = 'h03,
    parameter int unsigned GAP_W    = 8,
    localparam int unsigned DLEN_W  = $clog2(DATA_MAX + 1),
    localparam int unsigned CLEN_W  = $clog2(CRC_MAX + 1),
    localparam int unsigned IDX_W   = $clog2(DATA_MAX + CRC_MAX + 1),
    localparam int unsigned DPOS_W  = $clog2(DATA_MAX),
    localparam int unsigned CPOS_W  = $clog2(CRC_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_third,
    input  logic                start,
    input  logic [DATA_MAX-1:0] tx_data,
    input  logic [DLEN_W-1:0]   data_len,
    input  logic [CLEN_W-1:0]   crc_len,
    input  logic [GAP_W-1:0]    gap_len,
    input  logic                ret_in,
    output logic                frame_n,
    output logic                data_n,
    output logic                ready,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_crc_err
);

    localparam logic [1:0] LAST_PHASE = 2'(STROBES_PER_BIT - 1);

    typedef struct packed {
        pwb_state_e         state;
        logic [1:0]         phase;
        logic [IDX_W-1:0]   idx;
        logic [DLEN_W-1:0]  dlen;
        logic [CLEN_W-1:0]  clen;
        logic [GAP_W-1:0]   gap;
        logic [DATA_MAX-1:0] txd;
        logic [DATA_MAX-1:0] rxd;
        logic [CRC_MAX-1:0] rxc;
        logic               frame_n;
        logic               data_n;
        logic               rx_valid;
        logic               rx_err;
    } eng_t;

    localparam eng_t ENG_RESET = '{
        state:    ST_IDLE,
        phase:    2'd0,
        idx:      '0,
        dlen:     DLEN_W'(DATA_MIN),
        clen:     '0,
        gap:      '0,
        txd:      '0,
        rxd:      '0,
        rxc:      '0,
        frame_n:  1'b1,
        data_n:   1'b1,
        rx_valid: 1'b0,
        rx_err:   1'b0
    };

    eng_t q, n;

    logic [DLEN_W-1:0]  lim_dlen;
    logic [CLEN_W-1:0]  lim_clen;
    logic               gap_done;
    logic               gap_load;
    logic               crc_clr;
    logic               crc_en;
    logic [1:0]         acc_din;
    logic [CRC_MAX-1:0] acc_crc [2];

    logic [IDX_W-1:0]   dlen_x;
    logic [IDX_W-1:0]   clen_x;
    logic [DPOS_W-1:0]  dpos;
    logic [CPOS_W-1:0]  cpos;
    logic               in_data;
    logic               last_bit;
    logic               bit_end;
    logic               cur_bit;
    logic [CRC_MAX-1:0] rxc_shift;
    logic [CRC_MAX-1:0] clen_mask;

    pwb_len_clamp #(
        .DATA_MIN (DATA_MIN),
        .DATA_MAX (DATA_MAX),
        .CRC_MAX  (CRC_MAX)
    ) u_clamp (
        .raw_dlen (data_len),
        .raw_clen (crc_len),
        .lim_dlen (lim_dlen),
        .lim_clen (lim_clen)
    );

    // Slot 0 accumulates the outgoing CRC, slot 1 the CRC of the reply.
    assign acc_din[0] = cur_bit;
    assign acc_din[1] = ret_in;

    for (genvar g = 0; g < 2; g++) begin : g_crc
        pwb_crc_acc #(
            .CRC_MAX (CRC_MAX),
            .TAPS    (CRC_TAPS)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (crc_clr),
            .en    (crc_en),
            .din   (acc_din[g]),
            .len   (q.clen),
            .crc   (acc_crc[g])
        );
    end

    pwb_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .count   (q.gap),
        .tick    (bit_third),
        .expired (gap_done)
    );

    // Position decode for the bit slot in progress.
    always_comb begin
        dlen_x   = IDX_W'(q.dlen);
        clen_x   = IDX_W'(q.clen);
        in_data  = (q.idx < dlen_x);
        last_bit = (q.idx == (dlen_x + clen_x - IDX_W'(1)));
        dpos     = DPOS_W'(dlen_x - q.idx - IDX_W'(1));
        cpos     = CPOS_W'(dlen_x + clen_x - q.idx - IDX_W'(1));
        cur_bit  = in_data ? q.txd[dpos] : acc_crc[0][cpos];
        bit_end  = (q.state == ST_BITS) && bit_third && (q.phase == LAST_PHASE);
        crc_clr  = (q.state == ST_IDLE) && start;
        crc_en   = bit_end && in_data;
        gap_load = bit_end && last_bit;
        rxc_shift = CRC_MAX'({q.rxc, ret_in});
        for (int i = 0; i < CRC_MAX; i++) begin
            clen_mask[i] = (i < int'(q.clen));
        end
    end

    // Next-state logic.
    always_comb begin
        n = q;
        n.rx_valid = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    n.state = ST_ARM;
                    n.txd   = tx_data;
                    n.dlen  = lim_dlen;
                    n.clen  = lim_clen;
                    n.gap   = gap_len;
                    n.rxd   = '0;
                    n.rxc   = '0;
                end
            end

            ST_ARM: begin
                if (bit_third) begin
                    n.frame_n = 1'b0;
                    n.phase   = 2'd0;
                    n.state   = ST_LEAD;
                end
            end

            ST_LEAD: begin
                if (bit_third) begin
                    if (q.phase == LAST_PHASE) begin
                        n.phase  = 2'd0;
                        n.idx    = '0;
                        n.data_n = 1'b0;
                        n.state  = ST_BITS;
                    end else begin
                        n.phase = q.phase + 2'd1;
                    end
                end
            end

            ST_BITS: begin
                if (bit_third) begin
                    if (q.phase == 2'd0) begin
                        n.phase = 2'd1;
                        if (cur_bit) begin
                            n.data_n = 1'b1;
                        end
                    end else if (q.phase == 2'd1) begin
                        n.phase  = LAST_PHASE;
                        n.data_n = 1'b1;
                    end else begin
                        n.phase = 2'd0;
                        if (in_data) begin
                            n.rxd = DATA_MAX'({q.rxd, ret_in});
                        end else begin
                            n.rxc = rxc_shift;
                        end
                        if (last_bit) begin
                            n.frame_n  = 1'b1;
                            n.rx_valid = 1'b1;
                            n.rx_err   = !in_data &&
                                         ((rxc_shift & clen_mask) != acc_crc[1]);
                            n.state    = ST_GAP;
                        end else begin
                            n.idx    = q.idx + IDX_W'(1);
                            n.data_n = 1'b0;
                        end
                    end
                end
            end

            ST_GAP: begin
                if (gap_done) begin
                    n.state = ST_IDLE;
                end
            end

            default: begin
                n = ENG_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= ENG_RESET;
        end else begin
            q <= n;
        end
    end

    assign frame_n    = q.frame_n;
    assign data_n     = q.data_n;
    assign ready      = (q.state == ST_IDLE);
    assign rx_valid   = q.rx_valid;
    assign rx_data    = q.rxd;
    assign rx_crc_err = q.rx_err;

endmodule

// File: rtl/pwb_frame_engine_chk.sv
module pwb_frame_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_third,
    input logic start,
    input logic ready,
    input logic frame_n,
    input logic data_n,
    input logic rx_valid
);

    // R3: the data line only pulses inside a frame
    a_r3_data_quiet_outside_frame: assert property (
        @(posedge clk) disable iff (!rst_n) frame_n |-> data_n
    );

    // R3: bus lines move only on timing strobes
    a_r3_lines_move_on_strobe: assert property (
        @(posedge clk) disable iff (!rst_n)
        !bit_third |=> ($stable(frame_n) && $stable(data_n))
    );

    // R2: an accepted command leaves the ready state at once
    a_r2_accept_drops_ready: assert property (
        @(posedge clk) disable iff (!rst_n) (start && ready) |=> !ready
    );

    // R9: the engine is never ready while a frame is open
    a_r9_ready_only_when_idle: assert property (
        @(posedge clk) disable iff (!rst_n) ready |-> frame_n
    );

    // R9: the closing edge of a frame enters the gap, not ready
    a_r9_close_enters_gap: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(frame_n) |-> !ready
    );

    // R7: result strobe coincides with the frame closing
    a_r7_valid_on_close: assert property (
        @(posedge clk) disable iff (!rst_n) rx_valid |-> $rose(frame_n)
    );

    // R7: result strobe lasts a single cycle
    a_r7_valid_single_cycle: assert property (
        @(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid
    );

endmodule

bind pwb_frame_engine pwb_frame_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_third (bit_third),
    .start     (start),
    .ready     (ready),
    .frame_n   (frame_n),
    .data_n    (data_n),
    .rx_valid  (rx_valid)
);

// File: tb/tb_pwb_frame_engine.sv
module tb_pwb_frame_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_third = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_data = '0;
    logic [4:0]  data_len = 5'd8;
    logic [3:0]  crc_len = 4'd4;
    logic [7:0]  gap_len = '0;
    logic        ret_in = 1'b1;
    logic        frame_n, data_n, ready, rx_valid, rx_crc_err;
    logic [15:0] rx_data;

    pwb_frame_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_third  (bit_third),
        .start      (start),
        .tx_data    (tx_data),
        .data_len   (data_len),
        .crc_len    (crc_len),
        .gap_len    (gap_len),
        .ret_in     (ret_in),
        .frame_n    (frame_n),
        .data_n     (data_n),
        .ready      (ready),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_crc_err (rx_crc_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [1:0] hist [0:8191];
    int   tcount = 0;
    int   fstart = -1000;
    int   frise  = -1000;
    logic prev_fr = 1'b1;
    logic reply [0:23];
    int   cur_n = 0;
    int   last_gap = 0;

    logic        got_flag = 1'b0;
    logic [15:0] got_data = '0;
    logic        got_err = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Strobe generator, bus recorder and reply responder: one strobe per 4 clocks.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            bit_third = 1'b1;
            @(negedge clk);
            bit_third = 1'b0;
            tcount++;
            hist[tcount % 8192] = {frame_n, data_n};
            if (prev_fr && !frame_n) fstart = tcount;
            if (!prev_fr && frame_n) frise = tcount;
            prev_fr = frame_n;
            if (!frame_n) begin
                int rel;
                rel = tcount - fstart;
                if (rel >= 3 && ((rel - 3) % 3) == 0 && ((rel - 3) / 3) < cur_n)
                    ret_in = reply[(rel - 3) / 3];
            end
            repeat (2) @(negedge clk);
        end
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            got_flag = 1'b1;
            got_data = rx_data;
            got_err  = rx_crc_err;
        end
    end

    function automatic logic [7:0] ref_crc(input logic [15:0] d, input int dl, input int cl);
        logic [7:0] c;
        logic       fb;
        c = '0;
        if (cl == 0) return '0;
        for (int i = dl - 1; i >= 0; i--) begin
            fb = c[cl - 1] ^ d[i];
            c  = c << 1;
            if (fb) c = c ^ 8'h03;
            for (int k = cl; k < 8; k++) c[k] = 1'b0;
        end
        return c;
    endfunction

    // Runs one frame and checks shape, content, reply and gap.
    task automatic run_frame(input logic [15:0] d, input int dl_raw, input int cl_raw,
                             input int gap, input bit corrupt, input bit inject,
                             output int bits_seen);
        int dl, cl, n, prev_rise, bad_width, fall_tick;
        logic [15:0] dmask, dd, rd;
        logic [7:0]  tcrc, rcrc;
        logic [23:0] exp_s, got_s;
        dl = (dl_raw < 8) ? 8 : ((dl_raw > 16) ? 16 : dl_raw);
        cl = (cl_raw > 8) ? 8 : cl_raw;
        n  = dl + cl;
        dmask = (dl == 16) ? 16'hFFFF : ((16'h1 << dl) - 16'h1);
        dd   = d & dmask;
        rd   = (d ^ 16'hA5C3) & dmask;
        tcrc = ref_crc(dd, dl, cl);
        rcrc = ref_crc(rd, dl, cl) ^ ((corrupt && cl > 0) ? 8'h01 : 8'h00);
        exp_s = '0;
        for (int b = 0; b < n; b++) begin
            if (b < dl) begin
                exp_s[b] = dd[dl - 1 - b];
                reply[b] = rd[dl - 1 - b];
            end else begin
                exp_s[b] = tcrc[cl - 1 - (b - dl)];
                reply[b] = rcrc[cl - 1 - (b - dl)];
            end
        end
        cur_n = n;
        got_flag = 1'b0;
        prev_rise = frise;
        while (!ready) @(negedge clk);
        tx_data = d; data_len = 5'(dl_raw); crc_len = 4'(cl_raw); gap_len = 8'(gap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tx_data = ~d; data_len = 5'd9; crc_len = 4'd0; gap_len = 8'd0;
        if (inject) begin
            repeat (30) @(negedge clk);
            tx_data = 16'h1234; data_len = 5'd16; crc_len = 4'd8;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (got_flag);
        repeat (2) @(negedge clk);
        fall_tick = fstart;

        // R9: idle gap before this frame
        chk((fall_tick - prev_rise) >= 3 * last_gap, "R9 gap strobes",
            fall_tick - prev_rise, 3 * last_gap);
        // R2: one bit-time lead, then first data fall
        chk(hist[fall_tick % 8192][0] && hist[(fall_tick + 1) % 8192][0] &&
            hist[(fall_tick + 2) % 8192][0] && !hist[(fall_tick + 3) % 8192][0],
            "R2 lead bit time", {hist[(fall_tick + 3) % 8192]}, 2'b00);
        bad_width = 0;
        got_s = '0;
        for (int b = 0; b < n; b++) begin
            int lows;
            lows = 0;
            for (int p = 0; p < 3; p++)
                if (!hist[(fall_tick + 3 + 3 * b + p) % 8192][0]) lows++;
            if (hist[(fall_tick + 3 + 3 * b) % 8192][0]) bad_width++;
            if (lows != 1 && lows != 2) bad_width++;
            if (hist[(fall_tick + 3 + 3 * b + 1) % 8192][0] && !hist[(fall_tick + 3 + 3 * b + 2) % 8192][0])
                bad_width++;
            got_s[b] = (lows == 1);
        end
        // R3: legal pulse shapes
        chk(bad_width == 0, "R3 pulse width", bad_width, 0);
        // R4 R5: data then CRC, MSB first
        chk(got_s == exp_s, "R4 R5 bit stream", int'(got_s), int'(exp_s));
        bits_seen = (frise - fall_tick) / 3 - 1;
        // R6: frame closes at the end of the last bit
        chk((frise - fall_tick) == 3 * (1 + n), "R6 frame length", frise - fall_tick, 3 * (1 + n));
        // R7: received data right-aligned
        chk(got_data == rd, "R7 rx data", got_data, rd);
        // R8: CRC mismatch flag
        chk(got_err == (corrupt && cl > 0), "R8 crc flag", got_err, (corrupt && cl > 0));
        last_gap = gap;
    endtask

    task automatic t_reset();
        chk(frame_n === 1'b1 && data_n === 1'b1, "R1 bus idle", {frame_n, data_n}, 2'b11);
        chk(ready === 1'b1 && rx_valid === 1'b0, "R1 ready/valid", {ready, rx_valid}, 2'b10);
    endtask

    task automatic t_basic();
        int nb;
        run_frame(16'h00B7, 8, 4, 2, 1'b0, 1'b0, nb);
    endtask

    task automatic t_no_crc();
        int nb;
        run_frame(16'hC3A5, 16, 0, 0, 1'b0, 1'b0, nb);
        chk(nb == 16, "R5 no crc bits", nb, 16);
    endtask

    task automatic t_long_crc();
        int nb;
        run_frame(16'h5E1F, 12, 8, 5, 1'b0, 1'b0, nb);
        run_frame(16'hFFFF, 16, 4, 1, 1'b0, 1'b0, nb);
        run_frame(16'h0000, 8, 1, 0, 1'b0, 1'b0, nb);
    endtask

    task automatic t_bad_crc();
        int nb;
        run_frame(16'h02D9, 10, 4, 3, 1'b1, 1'b0, nb);
        run_frame(16'h7A11, 15, 8, 0, 1'b1, 1'b0, nb);
    endtask

    task automatic t_clamp();
        int nb;
        run_frame(16'h0005, 3, 4, 0, 1'b0, 1'b0, nb);
        chk(nb == 12, "R10 short data raised", nb, 12);
        run_frame(16'h9C6B, 25, 13, 0, 1'b0, 1'b0, nb);
        chk(nb == 24, "R10 long lengths lowered", nb, 24);
    endtask

    task automatic t_ignore();
        int nb, stray;
        run_frame(16'h01A6, 9, 3, 2, 1'b0, 1'b1, nb);
        chk(nb == 12, "R11 mid-frame start ignored", nb, 12);
        while (!ready) @(negedge clk);
        stray = 0;
        repeat (80) begin
            @(negedge clk);
            if (!frame_n || !ready) stray++;
        end
        chk(stray == 0, "R11 no frame without start", stray, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_crc();
        t_long_crc();
        t_bad_crc();
        t_clamp();
        t_ignore();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule